// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block derives the bit-rate timing for an SPI master from the system clock. It produces a one-cycle tick strobe at twice the serial clock rate. Each tick marks one serial clock edge, so the shift engine can launch data on one edge and capture it on the other. Two division laws are available and are picked by a single mode input. The exponential law gives half-periods of 2^n system cycles. The linear law gives half-periods of n+1 system cycles. In both laws n is the 8-bit divider value.

The mode and divider inputs are taken in only while the enable input is low. While the divider runs, changes on them are held off until the next disable and re-enable. Each time enable rises the half-period counter starts from zero, so the first serial clock half-period is full length. The block also supplies a serial clock level that idles low and toggles on every tick, and a strobe that marks the ticks on which that level rises (leading edges). Choosing a divider for a target frequency is left to software.

Top module: `spi_sclk_divider`

## Requirements
- R1: After reset, tick_o, lead_o and sclk_o are all low.
- R2: With mode_i = 0 (exponential law) and divider n ≤ 15, consecutive ticks are 2^n system cycles apart. A full serial clock period is therefore 2^(n+1) cycles.
- R3: With mode_i = 1 (linear law) and divider n in 0..255, consecutive ticks are n+1 system cycles apart. A full serial clock period is therefore 2*(n+1) cycles.
- R4: With mode_i = 0, a divider value above 15 behaves exactly as 15 (half-period 32768 cycles).
- R5: Changes on mode_i and div_i while en_i is high have no effect. The setting present on the last clock edge with en_i low is used until en_i goes low again.
- R6: If en_i is first sampled high at clock edge E0, the first tick is registered at edge E0+L-1, where L is the half-period. The counter always restarts from zero.
- R7: tick_o is high for exactly one cycle per tick whenever L > 1. With L = 1 it is high on every cycle while enabled.
- R8: sclk_o toggles on every tick, starting low. lead_o is high together with tick_o exactly when that tick drives sclk_o high, so leading and trailing ticks alternate and the first one is leading.
- R9: One cycle after en_i is sampled low, tick_o, lead_o and sclk_o are low, and they stay low while en_i stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Divider run enable; setting is captured while low |
| mode_i | input | 1 | 0 = exponential law, 1 = linear law |
| div_i | input | 8 | Divider value n |
| tick_o | output | 1 | One-cycle strobe per serial clock edge |
| lead_o | output | 1 | Tick is a leading (rising) serial clock edge |
| sclk_o | output | 1 | Serial clock level, idles low |

## Verification
If the captured setting or the half-period limit is wrong, the spacing between ticks comes out wrong. This is visible at the second tick after enable, at most two half-periods in. A counter that is not cleared on enable shows up as a short or long first half-period, visible at the very first tick. A phase register that does not toggle or does not clear shows up as lead_o and sclk_o failing to alternate on consecutive ticks, or as sclk_o high one cycle after disable.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;

  localparam int DIV_W   = 8;
  localparam int EXP_MAX = 15;
  localparam int CNT_W   = (EXP_MAX > DIV_W) ? EXP_MAX : DIV_W;

  typedef enum logic {
    DIV_EXP = 1'b0,
    DIV_LIN = 1'b1
  } div_mode_e;

  // Terminal count of the half-period counter: half-period length minus one.
  function automatic logic [CNT_W-1:0] half_limit(div_mode_e m, logic [DIV_W-1:0] v);
    logic [DIV_W-1:0] e;
    logic [CNT_W:0]   p;
    logic [CNT_W-1:0] r;
    if (m == DIV_LIN) begin
      e = '0;
      p = '0;
      r = CNT_W'(v);
    end else begin
      e = (v > DIV_W'(EXP_MAX)) ? DIV_W'(EXP_MAX) : v;
      p = ((CNT_W+1)'(1) << e) - (CNT_W+1)'(1);
      r = p[CNT_W-1:0];
    end
    return r;
  endfunction

endpackage

// File: rtl/spi_div_cfg.sv
module spi_div_cfg
  import spi_div_pkg::*;
#(
  parameter int DW = DIV_W,
  parameter int CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          mode_i,
  input  logic [DW-1:0] div_i,
  output logic [CW-1:0] limit_o
);

  logic [CW-1:0] limit_q;
  logic          capture;

  assign capture = !en_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      limit_q <= '0;
    end else if (capture) begin
      limit_q <= half_limit(div_mode_e'(mode_i), div_i);
    end
  end

  assign limit_o = limit_q;

  // R5: setting is frozen while running
  p_cfg_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> $stable(limit_q));

endmodule

// File: rtl/spi_div_count.sv
module spi_div_count #(
  parameter int CW = spi_div_pkg::CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [CW-1:0] limit_i,
  output logic          hit_o
);

  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == limit_i);
  assign hit_o  = en_i && at_end;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !en_i) begin
      cnt_q <= '0;
    end else if (at_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // R6: counter never passes the terminal count while running
  p_cnt_bounded_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> cnt_q <= limit_i);

  // R6: counter starts from zero on every disable
  p_cnt_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);

endmodule

// File: rtl/spi_div_phase.sv
module spi_div_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic hit_i,
  output logic tick_o,
  output logic lead_o,
  output logic sclk_o
);

  logic tick_q, lead_q, sclk_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !en_i) begin
      tick_q <= 1'b0;
      lead_q <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      tick_q <= hit_i;
      lead_q <= hit_i && !sclk_q;
      if (hit_i) sclk_q <= !sclk_q;
    end
  end

  assign tick_o = tick_q;
  assign lead_o = lead_q;
  assign sclk_o = sclk_q;

  // R8: every tick flips the serial clock level
  p_tick_toggles_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |-> sclk_q != $past(sclk_q));

  // R8: lead flags only ticks that raise the level
  p_lead_rises_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_q |-> tick_q && sclk_q);

  // R9: disabled means quiet
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !tick_q && !lead_q && !sclk_q);

endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider
  import spi_div_pkg::*;
#(
  parameter int DW = DIV_W,
  parameter int CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          mode_i,
  input  logic [DW-1:0] div_i,
  output logic          tick_o,
  output logic          lead_o,
  output logic          sclk_o
);

  logic [CW-1:0] limit;
  logic          hit;

  spi_div_cfg #(.DW(DW), .CW(CW)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .mode_i  (mode_i),
    .div_i   (div_i),
    .limit_o (limit)
  );

  spi_div_count #(.CW(CW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .limit_i (limit),
    .hit_o   (hit)
  );

  spi_div_phase u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .hit_i  (hit),
    .tick_o (tick_o),
    .lead_o (lead_o),
    .sclk_o (sclk_o)
  );

  // R7: tick is a single-cycle pulse unless the half-period is one cycle
  p_pulse_narrow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && en_i && limit != '0) |=> !tick_o);

  // R1: outputs are low right after reset
  p_reset_low_r1: assert property (@(posedge clk_i)
    !rst_ni |=> !tick_o && !lead_o && !sclk_o);

endmodule

// File: tb/spi_sclk_divider_tb.sv
module spi_sclk_divider_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       mode = 1'b0;
  logic [7:0] div = 8'd0;
  logic       tick, lead, sclk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spi_sclk_divider u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode), .div_i(div),
    .tick_o(tick), .lead_o(lead), .sclk_o(sclk)
  );

  function automatic int exp_half(bit m, int n);
    if (m) return n + 1;
    if (n > 15) n = 15;
    return 2 ** n;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Enable with the setting already on the inputs, then time three ticks.
  task automatic run(string req, bit m, int n, bit poke);
    int L, k, seen, narrow_bad;
    int t[3];
    int ld[3];
    int sc[3];
    bit prev;
    L = exp_half(m, n);
    @(negedge clk);
    en = 1'b1;
    k = 0; seen = 0; narrow_bad = 0; prev = 1'b0;
    while (seen < 3 && k < 4 * L + 10) begin
      @(negedge clk);
      k++;
      if (poke && k == 2) begin
        mode = ~m;
        div = 8'(n + 7);
      end
      if (tick) begin
        if (prev && L > 1) narrow_bad++;
        t[seen] = k; ld[seen] = lead; sc[seen] = sclk;
        seen++;
      end
      prev = tick;
    end
    check({req, " R6 first tick"}, (seen > 0) ? t[0] : -1, L);
    check({req, " spacing"}, (seen > 2) ? t[2] - t[1] : -1, L);
    check({req, " spacing2"}, (seen > 1) ? t[1] - t[0] : -1, L);
    check("R7 pulse width", narrow_bad, 0);
    check("R8 lead first", ld[0], 1);
    check("R8 lead second", ld[1], 0);
    check("R8 sclk toggles", sc[0] * 2 + sc[1] * 1 + 0, 2);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check("R9 idle tick", tick, 0);
    check("R9 idle sclk", sclk, 0);
    check("R9 idle lead", lead, 0);
  endtask

  task automatic setup(bit m, int n);
    @(negedge clk);
    mode = m;
    div = 8'(n);
    @(negedge clk);
  endtask

  initial begin
    int q;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 tick", tick, 0);
    check("R1 lead", lead, 0);
    check("R1 sclk", sclk, 0);
    rst_n = 1'b1;

    // directed corners
    setup(1'b0, 0);  run("R2 n=0", 1'b0, 0, 1'b0);
    setup(1'b1, 0);  run("R3 n=0", 1'b1, 0, 1'b0);
    setup(1'b0, 4);  run("R2 n=4", 1'b0, 4, 1'b0);
    setup(1'b1, 255); run("R3 n=255", 1'b1, 255, 1'b0);
    setup(1'b0, 200); run("R4 saturate", 1'b0, 200, 1'b0);

    // R5: inputs changed while running are ignored
    setup(1'b1, 3);  run("R5 frozen", 1'b1, 3, 1'b1);
    // re-enable picks up the value left on the inputs (mode 0, n=10)
    @(negedge clk);
    run("R5 reapplied", 1'b0, 10, 1'b0);

    // R9: long idle stays quiet
    setup(1'b1, 1);
    q = 0;
    repeat (20) begin
      @(negedge clk);
      if (tick || sclk) q++;
    end
    check("R9 long idle", q, 0);

    // random settings
    for (int i = 0; i < 14; i++) begin
      bit m;
      int n;
      m = 1'($urandom_range(0, 1));
      n = m ? int'($urandom_range(0, 255)) : int'($urandom_range(0, 7));
      setup(m, n);
      run(m ? "R3 random" : "R2 random", m, n, 1'b0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected < 190000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule